// File: doc/BRIEF.md
# DMA Descriptor Submission and Completion Report Queues

This block is the per-channel queue front end of a ring-based DMA engine. Software hands over work one 32-bit word at a time through a single descriptor write port. Four consecutive writes form one descriptor: buffer address low, buffer address high, length in bytes, and a flags word. An internal word counter builds the entry in staging registers. The entry enters a small descriptor ring only when its fourth word arrives.

A data mover, modelled here as a plain handshake, sees the head descriptor as a valid flag with the 64-bit address and the length. It takes the descriptor with a pop strobe and later reports the end of the transfer with a completion strobe and a byte count. Each completion becomes a four-word report in a second ring: address low, address high, completed bytes, status. Software drains a report with four consecutive reads of one read port. A one-cycle done pulse marks the completion of a descriptor whose flags asked for notification.

A control write with the ring-reset value set to 1 empties both rings and holds them empty until a write of 0 releases them.

Top module: `dma_queue_front`

## Requirements
- R1: A descriptor is taken from four accepted writes to `wr_data`, in the order address bits 31:0, address bits 63:32, length, flags. It becomes visible on `cons_valid`/`cons_addr`/`cons_len` only after the fourth word, and descriptors leave in submission order.
- R2: The descriptor ring holds DEPTH (default 4) entries. `desc_status` bit 9 is 1 exactly while the ring is full, and all other bits except bit 10 read 0.
- R3: A first word written while the descriptor ring is full, with no pop in the same cycle, is dropped and leaves the word counter unchanged. Every such drop sets `desc_status` bit 10, which stays set until a ring reset.
- R4: `cons_pop` while `cons_valid` is 1 removes the head descriptor and makes it the single in-flight transfer. `cons_valid` stays 0 until that transfer completes.
- R5: A `cmp_valid` strobe while a transfer is in flight writes a report of four words: address bits 31:0, address bits 63:32, `cmp_bytes`, then a status word. The status word has bit 16 set to the notify bit of the descriptor, bit 0 set to 1 when `cmp_bytes` differs from the descriptor length, and all other bits 0.
- R6: `rpt_status` bit 8 is 1 exactly while the report ring is empty. `rd_data` shows the current word of the oldest report, and each `rd_en` advances one word. The fourth read frees the report.
- R7: While the report ring is empty, `rd_data` is 0 and `rd_en` has no effect on the read position.
- R8: `desc_done` is 1 for exactly the one cycle after the clock edge that stores the report of a descriptor whose flags word had bit 16 set, and is 0 otherwise.
- R9: Writing `ctl_reset_val`=1 with `ctl_we` clears both rings, the word counter, the in-flight transfer and both overflow flags at once. The rings stay empty and all port writes, reads, pops and completions are ignored until a control write of 0.
- R10: The report ring holds RDEPTH (default 4) reports. A completion that finds it full, without the last word of a report being read in the same cycle, is dropped. The drop sets sticky `rpt_status` bit 9, still ends the transfer and gives no `desc_done`.
- R11: A slot freed in a cycle is usable in that same cycle. A first word written to a full descriptor ring together with a pop is accepted. A completion arriving with the fourth read of a report in a full report ring is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_data | input | 32 | Descriptor word |
| rd_en | input | 1 | Report word read strobe |
| rd_data | output | 32 | Current report word, 0 when empty |
| ctl_we | input | 1 | Control write strobe |
| ctl_reset_val | input | 1 | Ring-reset value written by the control write |
| desc_status | output | 32 | Bit 9 full, bit 10 sticky overflow |
| rpt_status | output | 32 | Bit 8 empty, bit 9 sticky overflow |
| cons_valid | output | 1 | Head descriptor available to the mover |
| cons_addr | output | 64 | Head descriptor buffer address |
| cons_len | output | 32 | Head descriptor length in bytes |
| cons_pop | input | 1 | Mover takes the head descriptor |
| cmp_valid | input | 1 | Mover completes the in-flight transfer |
| cmp_bytes | input | 32 | Bytes actually moved |
| desc_done | output | 1 | One-cycle notify-completion pulse |

## Verification
Two pairs of functions can fall in the same cycle. One is the admission of a new first word and a pop on a full descriptor ring. The other is a completion and the freeing fourth read on a full report ring. The bench fills each ring to its limit, then drives both strobes in a single cycle. It judges the result by the full flag staying set, by the overflow flags staying clear, and by the new entry appearing last in the drained order with its exact words.

// File: rtl/dma_queue_front.sv
module dma_queue_front #(
  parameter int DEPTH  = 4,
  parameter int RDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  input  logic        ctl_we,
  input  logic        ctl_reset_val,
  output logic [31:0] desc_status,
  output logic [31:0] rpt_status,
  output logic        cons_valid,
  output logic [63:0] cons_addr,
  output logic [31:0] cons_len,
  input  logic        cons_pop,
  input  logic        cmp_valid,
  input  logic [31:0] cmp_bytes,
  output logic        desc_done
);

  localparam int PW  = (DEPTH  > 1) ? $clog2(DEPTH)  : 1;
  localparam int RPW = (RDEPTH > 1) ? $clog2(RDEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int RCW = $clog2(RDEPTH + 1);
  localparam logic [CW-1:0]  D_FULL = CW'(DEPTH);
  localparam logic [RCW-1:0] R_FULL = RCW'(RDEPTH);
  localparam logic [PW-1:0]  D_LAST = PW'(DEPTH - 1);
  localparam logic [RPW-1:0] R_LAST = RPW'(RDEPTH - 1);

  logic          hold;
  logic [1:0]    wcnt;
  logic [31:0]   stg_lo, stg_hi, stg_len;

  logic [63:0]   d_addr [DEPTH];
  logic [31:0]   d_len  [DEPTH];
  logic          d_ntf  [DEPTH];
  logic [PW-1:0] d_wp, d_rp;
  logic [CW-1:0] d_cnt;
  logic          d_ovf;

  logic          busy;
  logic [63:0]   f_addr;
  logic [31:0]   f_len;
  logic          f_ntf;

  logic [63:0]    r_addr  [RDEPTH];
  logic [31:0]    r_bytes [RDEPTH];
  logic [31:0]    r_stat  [RDEPTH];
  logic [RPW-1:0] r_wp, r_rp;
  logic [RCW-1:0] r_cnt;
  logic [1:0]     rword;
  logic           r_ovf;

  wire clr     = hold || (ctl_we && ctl_reset_val);
  wire d_full  = d_cnt == D_FULL;
  wire d_empty = d_cnt == '0;
  wire r_full  = r_cnt == R_FULL;
  wire r_empty = r_cnt == '0;

  assign cons_valid = !d_empty && !busy && !hold;
  assign cons_addr  = d_addr[d_rp];
  assign cons_len   = d_len[d_rp];

  wire pop_ok  = cons_pop && cons_valid;
  wire wr_ok   = wr_en && !hold && (wcnt != 2'd0 || !d_full || pop_ok);
  wire wr_drop = wr_en && !hold && !wr_ok;
  wire push    = wr_ok && wcnt == 2'd3;
  wire rd_ok   = rd_en && !hold && !r_empty;
  wire r_pop   = rd_ok && rword == 2'd3;
  wire cmp_ok  = cmp_valid && busy && !hold;
  wire r_push  = cmp_ok && (!r_full || r_pop);
  wire r_drop  = cmp_ok && !r_push;

  assign desc_status = {21'b0, d_ovf, d_full, 9'b0};
  assign rpt_status  = {22'b0, r_ovf, r_empty, 8'b0};

  always_comb begin
    rd_data = '0;
    if (!r_empty) begin
      case (rword)
        2'd0:    rd_data = r_addr[r_rp][31:0];
        2'd1:    rd_data = r_addr[r_rp][63:32];
        2'd2:    rd_data = r_bytes[r_rp];
        default: rd_data = r_stat[r_rp];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      case (wcnt)
        2'd0:    stg_lo  <= wr_data;
        2'd1:    stg_hi  <= wr_data;
        2'd2:    stg_len <= wr_data;
        default: ;
      endcase
    end
    if (push) begin
      d_addr[d_wp] <= {stg_hi, stg_lo};
      d_len[d_wp]  <= stg_len;
      d_ntf[d_wp]  <= wr_data[16];
    end
    if (pop_ok) begin
      f_addr <= cons_addr;
      f_len  <= cons_len;
      f_ntf  <= d_ntf[d_rp];
    end
    if (r_push) begin
      r_addr[r_wp]  <= f_addr;
      r_bytes[r_wp] <= cmp_bytes;
      r_stat[r_wp]  <= {15'b0, f_ntf, 15'b0, cmp_bytes != f_len};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= 1'b0;
      wcnt      <= '0;
      d_wp      <= '0;
      d_rp      <= '0;
      d_cnt     <= '0;
      d_ovf     <= 1'b0;
      busy      <= 1'b0;
      r_wp      <= '0;
      r_rp      <= '0;
      r_cnt     <= '0;
      rword     <= '0;
      r_ovf     <= 1'b0;
      desc_done <= 1'b0;
    end else begin
      if (ctl_we) hold <= ctl_reset_val;
      if (clr) begin
        wcnt      <= '0;
        d_wp      <= '0;
        d_rp      <= '0;
        d_cnt     <= '0;
        d_ovf     <= 1'b0;
        busy      <= 1'b0;
        r_wp      <= '0;
        r_rp      <= '0;
        r_cnt     <= '0;
        rword     <= '0;
        r_ovf     <= 1'b0;
        desc_done <= 1'b0;
      end else begin
        if (wr_ok)   wcnt  <= wcnt + 2'd1;
        if (wr_drop) d_ovf <= 1'b1;
        if (push)    d_wp  <= (d_wp == D_LAST) ? '0 : d_wp + 1'b1;
        if (pop_ok)  d_rp  <= (d_rp == D_LAST) ? '0 : d_rp + 1'b1;
        d_cnt <= d_cnt + CW'(push) - CW'(pop_ok);
        if (pop_ok)      busy <= 1'b1;
        else if (cmp_ok) busy <= 1'b0;
        if (rd_ok)  rword <= rword + 2'd1;
        if (r_pop)  r_rp  <= (r_rp == R_LAST) ? '0 : r_rp + 1'b1;
        if (r_push) r_wp  <= (r_wp == R_LAST) ? '0 : r_wp + 1'b1;
        r_cnt <= r_cnt + RCW'(r_push) - RCW'(r_pop);
        if (r_drop) r_ovf <= 1'b1;
        desc_done <= r_push && f_ntf;
      end
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt <= D_FULL);

  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop && !clr |=> wcnt == 2'd0 && d_ovf);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    d_ovf && !clr |=> d_ovf);

  p_pop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && !clr |=> busy && !cons_valid);

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && r_empty |=> $stable(r_rp) && rword == 2'd0);

  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> $past(cmp_valid));

  p_rpt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_cnt <= R_FULL);

  p_drop_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    r_drop |=> !desc_done && r_ovf);

endmodule

// File: tb/test_dma_queue_front.sv
module test_dma_queue_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, ctl_we, ctl_reset_val, cons_pop, cmp_valid;
  logic [31:0] wr_data, rd_data, desc_status, rpt_status, cons_len, cmp_bytes;
  logic [63:0] cons_addr;
  logic        cons_valid, desc_done;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_queue_front i_dma_queue_front (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ctl_we(ctl_we), .ctl_reset_val(ctl_reset_val),
    .desc_status(desc_status), .rpt_status(rpt_status), .cons_valid(cons_valid),
    .cons_addr(cons_addr), .cons_len(cons_len), .cons_pop(cons_pop),
    .cmp_valid(cmp_valid), .cmp_bytes(cmp_bytes), .desc_done(desc_done));

  // addr, len, flags, completed bytes
  localparam logic [159:0] VEC [4] = '{
    {64'h0000_0001_2345_6780, 32'd256,    32'h0001_0000, 32'd256},
    {64'hFFFF_0000_0000_0040, 32'd64,     32'h0000_0000, 32'd48},
    {64'h8000_0000_DEAD_BEE0, 32'h1000,   32'h0001_FFFF, 32'h800},
    {64'h0000_0000_0000_0000, 32'd4,      32'hFFFE_FFFF, 32'd4}};

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_word(logic [31:0] w);
    wr_en = 1'b1; wr_data = w; tick; wr_en = 1'b0;
  endtask

  task automatic submit(logic [63:0] a, logic [31:0] l, logic [31:0] f);
    put_word(a[31:0]); put_word(a[63:32]); put_word(l); put_word(f);
  endtask

  task automatic pop; cons_pop = 1'b1; tick; cons_pop = 1'b0; endtask

  task automatic complete(logic [31:0] b);
    cmp_valid = 1'b1; cmp_bytes = b; tick; cmp_valid = 1'b0;
  endtask

  task automatic read_chk(string tag, logic [31:0] exp);
    chk(tag, {32'b0, rd_data}, {32'b0, exp});
    rd_en = 1'b1; tick; rd_en = 1'b0;
  endtask

  task automatic report_chk(string tag, logic [63:0] a, logic [31:0] b, logic [31:0] st);
    read_chk({tag, " word0"}, a[31:0]);
    read_chk({tag, " word1"}, a[63:32]);
    read_chk({tag, " word2"}, b);
    read_chk({tag, " word3"}, st);
  endtask

  function automatic logic [31:0] stat_of(logic [31:0] f, logic [31:0] l, logic [31:0] b);
    return {15'b0, f[16], 15'b0, b != l};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; rd_en = 0; ctl_we = 0; ctl_reset_val = 0;
    cons_pop = 0; cmp_valid = 0; cmp_bytes = 0;
    repeat (3) tick;
    rst_n = 1'b1; tick;

    chk("R2 reset desc_status", {32'b0, desc_status}, 64'h0);
    chk("R6 reset rpt empty", {32'b0, rpt_status}, 64'h100);
    chk("R4 reset cons_valid", {63'b0, cons_valid}, 64'h0);
    chk("R7 reset rd_data", {32'b0, rd_data}, 64'h0);
    chk("R8 reset done", {63'b0, desc_done}, 64'h0);

    for (int i = 0; i < 4; i++) begin
      logic [63:0] a; logic [31:0] l, f, b;
      {a, l, f, b} = VEC[i];
      submit(a, l, f);
      chk("R1 vec valid", {63'b0, cons_valid}, 64'h1);
      chk("R1 vec addr", cons_addr, a);
      chk("R1 vec len", {32'b0, cons_len}, {32'b0, l});
      pop;
      chk("R4 busy blocks valid", {63'b0, cons_valid}, 64'h0);
      complete(b);
      chk("R8 done pulse", {63'b0, desc_done}, {63'b0, f[16]});
      tick;
      chk("R8 done one cycle", {63'b0, desc_done}, 64'h0);
      chk("R6 not empty", {63'b0, rpt_status[8]}, 64'h0);
      report_chk("R5 vec report", a, b, stat_of(f, l, b));
      chk("R6 empty after drain", {63'b0, rpt_status[8]}, 64'h1);
    end

    put_word(32'h0000_1000); put_word(32'h10); put_word(32'd16);
    chk("R1 partial invisible", {63'b0, cons_valid}, 64'h0);
    put_word(32'h0);
    chk("R1 fourth word visible", {63'b0, cons_valid}, 64'h1);
    chk("R1 assembled addr", cons_addr, 64'h10_0000_1000);
    submit(64'h2000, 16, 0); submit(64'h3000, 16, 0); submit(64'h4000, 16, 0);
    chk("R2 full flag", {32'b0, desc_status}, 64'h200);

    wr_en = 1'b1; wr_data = 32'h5000; cons_pop = 1'b1; tick;
    wr_en = 1'b0; cons_pop = 1'b0;
    put_word(32'h0); put_word(32'd16); put_word(32'h0);
    chk("R11 push with pop keeps full, no overflow", {32'b0, desc_status}, 64'h200);
    complete(16);
    report_chk("R11 popped head report", 64'h10_0000_1000, 16, 0);

    submit(64'h6000, 16, 0);
    chk("R3 overflow sticky set", {32'b0, desc_status}, 64'h600);
    for (int k = 0; k < 4; k++) begin
      logic [63:0] ea;
      ea = 64'h2000 + 64'h1000 * k;
      chk("R1 order after overflow", cons_addr, ea);
      pop; complete(16);
      report_chk("R11 drained report", ea, 16, 0);
    end
    chk("R3 dropped descriptor absent", {63'b0, cons_valid}, 64'h0);
    chk("R3 overflow stays", {32'b0, desc_status}, 64'h400);

    chk("R7 empty read zero", {32'b0, rd_data}, 64'h0);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    chk("R7 still empty", {32'b0, rpt_status}, 64'h100);
    submit(64'h7000, 8, 32'h1_0000); pop; complete(8);
    report_chk("R7 pointer unmoved", 64'h7000, 8, 32'h1_0000);

    for (int k = 0; k < 4; k++) begin
      submit(64'h8000 + 64'h100 * k, 32, 0); pop; complete(32);
    end
    chk("R10 ring full no overflow", {32'b0, rpt_status}, 64'h0);
    submit(64'h8400, 32, 32'h1_0000); pop; complete(32);
    chk("R10 dropped no done", {63'b0, desc_done}, 64'h0);
    chk("R10 overflow set", {32'b0, rpt_status}, 64'h200);
    chk("R10 transfer ended", {63'b0, cons_valid}, 64'h0);
    submit(64'h8500, 40, 32'h1_0000); pop;
    read_chk("R11 head word0", 32'h8000);
    read_chk("R11 head word1", 32'h0);
    read_chk("R11 head word2", 32'd32);
    rd_en = 1'b1; cmp_valid = 1'b1; cmp_bytes = 32'd40; tick;
    rd_en = 1'b0; cmp_valid = 1'b0;
    chk("R11 completion with final read stored", {63'b0, desc_done}, 64'h1);
    chk("R11 report ring still full", {63'b0, rpt_status[8]}, 64'h0);
    for (int k = 1; k < 4; k++)
      report_chk("R10 kept report", 64'h8000 + 64'h100 * k, 32, 0);
    report_chk("R11 late report last", 64'h8500, 40, 32'h1_0000);
    chk("R10 drained empty", {63'b0, rpt_status[8]}, 64'h1);

    put_word(32'hAAAA); put_word(32'hBBBB);
    ctl_we = 1'b1; ctl_reset_val = 1'b1; tick; ctl_we = 1'b0;
    chk("R9 overflow flags cleared", {32'b0, desc_status}, 64'h0);
    chk("R9 report flags cleared", {32'b0, rpt_status}, 64'h100);
    submit(64'hC000, 8, 0);
    chk("R9 writes ignored in hold", {63'b0, cons_valid}, 64'h0);
    ctl_we = 1'b1; ctl_reset_val = 1'b0; tick; ctl_we = 1'b0;
    chk("R9 empty after release", {63'b0, cons_valid}, 64'h0);
    submit(64'h9000, 32, 0);
    chk("R9 word counter cleared addr", cons_addr, 64'h9000);
    chk("R9 word counter cleared len", {32'b0, cons_len}, 64'd32);
    pop; complete(32);
    report_chk("R9 report after release", 64'h9000, 32, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule